// File: doc/BRIEF.md
# I2C Target Controller with Stretch Control

This block is a byte-level I2C target (slave) engine with a 7-bit address. It watches the open-drain SCL and SDA lines through a synchronizer and answers its own address or the general call address. It acknowledges or refuses each byte, takes in written bytes, and shifts out bytes for reads. A 16-bit control word, written through a simple write port and readable at any time, configures it.

The control word controls several things. Firmware can refuse the next byte. It can hold SCL low on demand. It can choose whether the transmit request interrupt fires on the rising or the falling SCL edge of the read/write bit. The block can also recognise a hardware general call, which is the general call address followed by a byte that matches a programmed alternate ID. Separate enable bits gate the interrupts for a received byte, a transmitted byte and a stop condition. When a read has no data ready, the block holds SCL low by itself until firmware loads a byte.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset the control word, status word, interrupt and both line drivers are all zero. The control word reads back only bits 10:5, 3, 2 and 0. Bits 15:11, 4 and 1 always read 0.
- R2: When control bit 0 (enable) is set and the address byte (7 address bits MSB first, then the R/W bit with 1 = read) matches `own_addr`, SDA is pulled low in the ninth clock. A different address or a cleared bit 0 leaves both lines released.
- R3: In a write, each data byte is shifted in MSB first, appears on `rx_data` and is acknowledged.
- R4: When control bit 7 is set, the ninth-clock acknowledge of the address or data byte is withheld (SDA stays high). The data byte is still captured.
- R5: In a read, the loaded byte is driven MSB first. The transfer ends when the master refuses the byte.
- R6: After the acknowledge of a read address, if no byte is loaded, SCL is held low until `tx_load` is pulsed. The loaded byte is then sent.
- R7: Control bit 6 holds SCL low. If SCL is low when the bit is set, the hold starts at once. If SCL is high, the hold starts at the next falling edge. The hold ends when the bit is cleared.
- R8: With control bit 10 set, a transmit request interrupt fires for a matched read address. With bit 5 set it fires after the rising SCL edge of the R/W bit. With bit 5 clear it fires after the falling edge of that bit.
- R9: With bit 8 set, a stop condition after this target was addressed raises an interrupt. The last interrupt cause appears in status[10:8] (1 receive, 2 byte sent, 3 stop, 4 transmit request).
- R10: With bit 2 set, address 0x00 (write) is acknowledged and sets status[2] with ID status[1:0] = 01. With bit 2 clear it is not acknowledged.
- R11: With bits 3 and 2 set, a first data byte after a general call that equals `alt_id` sets ID status[1:0] = 11.
- R12: Writing a control word with bit 4 set clears status[2:0] in the same write.
- R13: Received-byte (bit 9), sent-byte (bit 10) and stop (bit 8) interrupts fire only when their enable bit is set. Each interrupt is a one-cycle pulse on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word read value |
| own_addr | input | 7 | Target address |
| alt_id | input | 8 | Alternate ID for the hardware general call |
| tx_data | input | 8 | Byte to send in reads |
| tx_load | input | 1 | Loads `tx_data` into the transmit buffer |
| rx_data | output | 8 | Last received byte |
| status | output | 16 | [10:8] last cause, [4] read, [3] addressed, [2] general call, [1:0] general call ID |
| irq | output | 1 | Interrupt pulse |

## Verification
Address bytes are tried as an exact match, a one-bit mismatch, the general call with and without its enable, and with the block disabled. This separates address decoding from the enable and refuse paths. Write and read transfers use alternating-bit and mixed data patterns under different interrupt enable masks, so the count of `irq` pulses shows which sources are gated. Directed runs place the transmit request on each SCL edge. They also let SCL stall both with and without a loaded byte, and they send a general call whose second byte either matches or misses the alternate ID.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
   localparam int CTL_W = 16;

   // control bit positions
   localparam int B_SLV_EN   = 0;
   localparam int B_GC_EN    = 2;
   localparam int B_HGC_EN   = 3;
   localparam int B_GC_CLR   = 4;
   localparam int B_EARLY_TX = 5;
   localparam int B_STRETCH  = 6;
   localparam int B_NACK     = 7;
   localparam int B_STOP_IE  = 8;
   localparam int B_RX_IE    = 9;
   localparam int B_TX_IE    = 10;

   // storable bits: 10:5, 3, 2, 0
   localparam logic [CTL_W-1:0] CTL_KEEP = 16'h07ED;

   localparam logic [2:0] CAUSE_RX    = 3'd1;
   localparam logic [2:0] CAUSE_TXB   = 3'd2;
   localparam logic [2:0] CAUSE_STOP  = 3'd3;
   localparam logic [2:0] CAUSE_TXREQ = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TXWAIT, ST_TX, ST_TXACK, ST_SKIP
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '1;
         prev <= 1'b1;
      end else begin
         q    <= {q[STAGES-2:0], line_i};
         prev <= q[STAGES-1];
      end
   end

   assign level_o = q[STAGES-1];
   assign rise_o  = q[STAGES-1] & ~prev;
   assign fall_o  = ~q[STAGES-1] & prev;
endmodule

// File: rtl/i2c_tgt_regs.sv
`timescale 1ns/1ps
module i2c_tgt_regs
   import i2c_tgt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output logic [CTL_W-1:0] ctrl_o,
   output logic             gc_clr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_o <= '0;
      else if (wr_en) ctrl_o <= wr_data & CTL_KEEP;
   end

   assign gc_clr_o = wr_en & wr_data[B_GC_CLR];
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter bit HGC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTL_W-1:0]  ctrl,
   input  logic              gc_clr,
   input  logic              scl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] alt_id,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic [15:0]       status,
   output logic              irq
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] TXLAST = CNT_W'(DATA_W - 1);

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, rx_q, tx_buf, tx_sh;
   logic              tx_valid, ack_drv, sda_drv, auto_hold, sw_hold;
   logic              rw_q, addressed, gc_phase, gc_flag, master_ack;
   logic [1:0]        gc_id;
   logic [2:0]        cause;

   logic              en, bus_start, bus_stop;
   logic [DATA_W-1:0] sh_next;
   logic              own_hit, own_hit_next, gc_hit, hgc_hit;
   logic              unused_ctrl;

   assign en           = ctrl[B_SLV_EN];
   assign bus_start    = sda_fall & scl;
   assign bus_stop     = sda_rise & scl;
   assign sh_next      = {shreg[DATA_W-2:0], sda};
   assign own_hit      = (shreg[DATA_W-1:1] == own_addr);
   assign own_hit_next = (sh_next[DATA_W-1:1] == own_addr);
   assign gc_hit       = (shreg[DATA_W-1:1] == '0) & ~shreg[0] & ctrl[B_GC_EN];
   assign unused_ctrl  = ^{ctrl[15:11], ctrl[B_GC_CLR], ctrl[1]};

   if (HGC_SUPPORT) begin : g_hgc
      assign hgc_hit = ctrl[B_HGC_EN] & ctrl[B_GC_EN] & (shreg == alt_id);
   end else begin : g_no_hgc
      logic unused_alt;
      assign unused_alt = ^{alt_id, ctrl[B_HGC_EN]};
      assign hgc_hit    = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  cnt <= '0;  shreg <= '0;  rx_q <= '0;
         tx_buf <= '0;  tx_sh <= '0;  tx_valid <= 1'b0;
         ack_drv <= 1'b0;  sda_drv <= 1'b0;  auto_hold <= 1'b0;  sw_hold <= 1'b0;
         rw_q <= 1'b0;  addressed <= 1'b0;  gc_phase <= 1'b0;  gc_flag <= 1'b0;
         master_ack <= 1'b0;  gc_id <= 2'b00;  cause <= 3'd0;  irq <= 1'b0;
      end else begin
         irq     <= 1'b0;
         sw_hold <= en & ctrl[B_STRETCH] & (sw_hold | ~scl);
         if (tx_load) begin
            tx_buf   <= tx_data;
            tx_valid <= 1'b1;
         end
         if (!en) begin
            state <= ST_IDLE;  ack_drv <= 1'b0;  sda_drv <= 1'b0;
            auto_hold <= 1'b0;  addressed <= 1'b0;
         end else if (bus_start) begin
            state <= ST_ADDR;  cnt <= '0;  ack_drv <= 1'b0;  sda_drv <= 1'b0;
            auto_hold <= 1'b0;  addressed <= 1'b0;
         end else if (bus_stop) begin
            if (addressed && ctrl[B_STOP_IE]) begin
               irq <= 1'b1;  cause <= CAUSE_STOP;
            end
            state <= ST_IDLE;  addressed <= 1'b0;  ack_drv <= 1'b0;
            sda_drv <= 1'b0;  auto_hold <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg <= sh_next;
                     cnt   <= cnt + 1'b1;
                     if (cnt == TXLAST && sh_next[0] && own_hit_next &&
                         ctrl[B_EARLY_TX] && ctrl[B_TX_IE]) begin
                        irq <= 1'b1;  cause <= CAUSE_TXREQ;
                     end
                  end else if (scl_fall && cnt == LAST) begin
                     if (own_hit || gc_hit) begin
                        addressed <= 1'b1;
                        rw_q      <= shreg[0];
                        ack_drv   <= ~ctrl[B_NACK];
                        gc_phase  <= gc_hit;
                        state     <= ST_ACK;
                        if (gc_hit) begin
                           gc_flag <= 1'b1;  gc_id <= 2'b01;
                        end
                        if (shreg[0] && !ctrl[B_EARLY_TX] && ctrl[B_TX_IE]) begin
                           irq <= 1'b1;  cause <= CAUSE_TXREQ;
                        end
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     ack_drv <= 1'b0;
                     cnt     <= '0;
                     if (!ack_drv) begin
                        state <= ST_SKIP;
                     end else if (!rw_q) begin
                        state <= ST_RX;
                     end else if (tx_valid) begin
                        tx_sh <= tx_buf;  tx_valid <= 1'b0;
                        sda_drv <= ~tx_buf[DATA_W-1];  state <= ST_TX;
                     end else begin
                        auto_hold <= 1'b1;  state <= ST_TXWAIT;
                     end
                  end
               end
               ST_TXWAIT: begin
                  if (tx_valid) begin
                     tx_sh <= tx_buf;  tx_valid <= 1'b0;
                     sda_drv <= ~tx_buf[DATA_W-1];
                     auto_hold <= 1'b0;  state <= ST_TX;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == TXLAST) begin
                        sda_drv <= 1'b0;
                        state   <= ST_TXACK;
                        if (ctrl[B_TX_IE]) begin
                           irq <= 1'b1;  cause <= CAUSE_TXB;
                        end
                     end else begin
                        tx_sh   <= tx_sh << 1;
                        sda_drv <= ~tx_sh[DATA_W-2];
                        cnt     <= cnt + 1'b1;
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     master_ack <= ~sda;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (!master_ack) begin
                        state <= ST_SKIP;
                     end else if (tx_valid) begin
                        tx_sh <= tx_buf;  tx_valid <= 1'b0;
                        sda_drv <= ~tx_buf[DATA_W-1];  state <= ST_TX;
                     end else begin
                        auto_hold <= 1'b1;  state <= ST_TXWAIT;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     shreg <= sh_next;
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     rx_q    <= shreg;
                     ack_drv <= ~ctrl[B_NACK];
                     state   <= ST_ACK;
                     if (ctrl[B_RX_IE]) begin
                        irq <= 1'b1;  cause <= CAUSE_RX;
                     end
                     if (gc_phase) begin
                        gc_phase <= 1'b0;
                        if (hgc_hit) gc_id <= 2'b11;
                     end
                  end
               end
               default: ;
            endcase
         end
         if (gc_clr) begin
            gc_flag <= 1'b0;
            gc_id   <= 2'b00;
         end
      end
   end

   assign scl_oe  = auto_hold | sw_hold;
   assign sda_oe  = ack_drv | sda_drv;
   assign rx_data = rx_q;
   assign status  = {5'd0, cause, 3'd0, rw_q & addressed, addressed, gc_flag, gc_id};
endmodule

// File: rtl/i2c_tgt_ctrl.sv
`timescale 1ns/1ps
module i2c_tgt_ctrl
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HGC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic              ctl_wr,
   input  logic [15:0]       ctl_wdata,
   output logic [15:0]       ctl_rdata,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] alt_id,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic [DATA_W-1:0] rx_data,
   output logic [15:0]       status,
   output logic              irq
);
   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("i2c_tgt_ctrl: DATA_W must equal ADDR_W + 1");
   end

   localparam int N_LINES = 2;   // index 0 = SCL, 1 = SDA

   logic [N_LINES-1:0] line_in, line_lvl, line_rise, line_fall;
   logic [CTL_W-1:0]   ctrl;
   logic               gc_clr;

   assign line_in = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (line_in[g]),
         .level_o(line_lvl[g]),
         .rise_o (line_rise[g]),
         .fall_o (line_fall[g])
      );
   end

   i2c_tgt_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl_wr),
      .wr_data (ctl_wdata),
      .ctrl_o  (ctrl),
      .gc_clr_o(gc_clr)
   );

   i2c_tgt_engine #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .HGC_SUPPORT(HGC_SUPPORT)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl    (ctrl),
      .gc_clr  (gc_clr),
      .scl     (line_lvl[0]),
      .scl_rise(line_rise[0]),
      .scl_fall(line_fall[0]),
      .sda     (line_lvl[1]),
      .sda_rise(line_rise[1]),
      .sda_fall(line_fall[1]),
      .own_addr(own_addr),
      .alt_id  (alt_id),
      .tx_data (tx_data),
      .tx_load (tx_load),
      .scl_oe  (scl_oe),
      .sda_oe  (sda_oe),
      .rx_data (rx_data),
      .status  (status),
      .irq     (irq)
   );

   assign ctl_rdata = ctrl;
endmodule

// File: rtl/i2c_tgt_chk.sv
`timescale 1ns/1ps
module i2c_tgt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ctl_wr,
   input logic [15:0] ctl_wdata,
   input logic [15:0] ctl_rdata,
   input logic [15:0] status,
   input logic        scl_oe,
   input logic        sda_oe,
   input logic        irq
);
   p_ctrl_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[15:11] == 5'd0) && !ctl_rdata[4] && !ctl_rdata[1]);

   p_off_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[0] |=> (!sda_oe && !scl_oe));

   p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status[10:8] != 3'd0));

   p_gc_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status[2] |-> (status[0] == 1'b1));

   p_gc_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !status[2] |-> (status[1:0] == 2'b00));

   p_gc_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[4]) |=> (status[2:0] == 3'b000));

   p_irq_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_wr   (ctl_wr),
   .ctl_wdata(ctl_wdata),
   .ctl_rdata(ctl_rdata),
   .status   (status),
   .scl_oe   (scl_oe),
   .sda_oe   (sda_oe),
   .irq      (irq)
);

// File: tb/sim_i2c_tgt_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_tgt_ctrl;
   localparam int H = 40;
   localparam int Q = 20;
   localparam logic [6:0] OWN = 7'h2A;

   // {ctrl16, addr7, rw1, data8, expect_ack1, expect_irqs2}
   localparam int NV = 11;
   localparam logic [34:0] VEC [NV] = '{
      {16'h0701, 7'h2A, 1'b0, 8'hA5, 1'b1, 2'd2},
      {16'h0701, 7'h2A, 1'b0, 8'h3C, 1'b1, 2'd2},
      {16'h0001, 7'h2A, 1'b0, 8'h5A, 1'b1, 2'd0},
      {16'h0701, 7'h2B, 1'b0, 8'h11, 1'b0, 2'd0},
      {16'h0700, 7'h2A, 1'b0, 8'h11, 1'b0, 2'd0},
      {16'h0781, 7'h2A, 1'b0, 8'h11, 1'b0, 2'd1},
      {16'h0701, 7'h2A, 1'b1, 8'hC3, 1'b1, 2'd3},
      {16'h0721, 7'h2A, 1'b1, 8'h96, 1'b1, 2'd3},
      {16'h0001, 7'h2A, 1'b1, 8'h01, 1'b1, 2'd0},
      {16'h0705, 7'h00, 1'b0, 8'h22, 1'b1, 2'd2},
      {16'h0701, 7'h00, 1'b0, 8'h22, 1'b0, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [7:0]  alt_id = 8'h35;
   logic [7:0]  tx_data = '0;
   logic        tx_load = 1'b0;
   logic        scl_oe, sda_oe, irq;
   logic [15:0] ctl_rdata, status;
   logic [7:0]  rx_data;
   wire         scl_bus = scl_m & ~scl_oe;
   wire         sda_bus = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;
   int irq_n  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   i2c_tgt_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .own_addr(OWN), .alt_id(alt_id), .tx_data(tx_data),
      .tx_load(tx_load), .rx_data(rx_data), .status(status), .irq(irq)
   );

   always @(negedge clk) if (rst_n && irq) irq_n++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_high();
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      @(negedge clk);
      ctl_wr = 1'b1;  ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
      wt(2);
   endtask

   task automatic load_tx(input logic [7:0] v);
      @(negedge clk);
      tx_data = v;  tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
   endtask

   task automatic bus_start();
      sda_m = 1'b1;  scl_m = 1'b1;  wt(H);
      sda_m = 1'b0;  wt(H);
      scl_m = 1'b0;  wt(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;  wt(Q);
      scl_m = 1'b1;  wait_high();  wt(H);
      sda_m = 1'b1;  wt(H);
   endtask

   task automatic write_bit(input logic b);
      sda_m = b;  wt(Q);
      scl_m = 1'b1;  wait_high();  wt(H);
      scl_m = 1'b0;  wt(Q);
   endtask

   task automatic read_bit(output logic b);
      sda_m = 1'b1;  wt(Q);
      scl_m = 1'b1;  wait_high();  wt(H / 2);
      b = sda_bus;   wt(H / 2);
      scl_m = 1'b0;  wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) write_bit(v[i]);
      read_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         read_bit(b);
         v[i] = b;
      end
      write_bit(~ack);
   endtask

   task automatic early_late(input bit early);
      logic       ack;
      logic [7:0] got;
      int         base;
      wr_ctl(early ? 16'h0421 : 16'h0401);
      load_tx(8'h5A);
      bus_start();
      for (int i = 6; i >= 0; i--) write_bit(OWN[i]);
      base = irq_n;
      sda_m = 1'b1;  wt(Q);
      scl_m = 1'b1;  wait_high();  wt(H / 2);
      chk((irq_n - base) == (early ? 1 : 0), "R8 request during R/W high", irq_n - base, early ? 1 : 0);
      wt(H / 2);
      scl_m = 1'b0;  wt(Q);
      chk((irq_n - base) == 1, "R8 request after R/W fall", irq_n - base, 1);
      read_bit(ack);
      chk(ack == 1'b0, "R8 read address acked (SDA low)", ack, 0);
      recv_byte(got, 1'b0);
      chk(got == 8'h5A, "R5 read data", got, 8'h5A);
      bus_stop();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic       ack;
      logic [7:0] got;
      int         base;
      wt(5);
      // reset state, R1
      chk(ctl_rdata == 16'h0, "R1 ctrl reset", ctl_rdata, 0);
      chk(status == 16'h0, "R1 status reset", status, 0);
      chk({scl_oe, sda_oe, irq} == 3'b000, "R1 outputs reset", {scl_oe, sda_oe, irq}, 0);
      rst_n = 1'b1;
      wt(5);
      wr_ctl(16'hFFFF);
      chk(ctl_rdata == 16'h07ED, "R1 stored bits", ctl_rdata, 16'h07ED);
      wr_ctl(16'h0010);
      chk(status[2:0] == 3'b000, "R12 clear on idle", status[2:0], 0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         logic [34:0] v;
         v = VEC[k];
         wr_ctl(16'h0010);
         wr_ctl(v[34:19]);
         if (v[11]) load_tx(v[10:3]);
         base = irq_n;
         bus_start();
         send_byte({v[18:12], v[11]}, ack);
         chk(ack == v[2], "R2/R4/R10 address acknowledge", ack, v[2]);
         if (ack && !v[11]) begin
            send_byte(v[10:3], ack);
            chk(ack == 1'b1, "R3 data acknowledge", ack, 1);
            chk(rx_data == v[10:3], "R3 rx_data", rx_data, v[10:3]);
         end else if (ack && v[11]) begin
            recv_byte(got, 1'b0);
            chk(got == v[10:3], "R5 read byte", got, v[10:3]);
         end
         bus_stop();
         chk((irq_n - base) == int'(v[1:0]), "R13 irq count", irq_n - base, v[1:0]);
         if (v[1:0] != 2'd0)
            chk(status[10:8] == 3'd3, "R9 last cause stop", status[10:8], 3);
         if (v[18:12] == 7'h00 && ack)
            chk(status[2:0] == 3'b101, "R10 general call status", status[2:0], 3'b101);
      end

      // R4: refuse a data byte
      wr_ctl(16'h0001);
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      chk(ack == 1'b1, "R4 address ack before refuse", ack, 1);
      wr_ctl(16'h0081);
      send_byte(8'h77, ack);
      chk(ack == 1'b0, "R4 data refused", ack, 0);
      chk(rx_data == 8'h77, "R4 data still captured", rx_data, 8'h77);
      bus_stop();

      // R11, R12, R10: hardware general call
      wr_ctl(16'h0010);
      wr_ctl(16'h000D);
      bus_start();
      send_byte(8'h00, ack);
      chk(ack == 1'b1, "R10 general call acked", ack, 1);
      send_byte(8'h35, ack);
      bus_stop();
      chk(status[2:0] == 3'b111, "R11 hardware general call id", status[2:0], 3'b111);
      wr_ctl(16'h001D);
      chk(status[2:0] == 3'b000, "R12 clear bit", status[2:0], 0);
      chk(ctl_rdata == 16'h000D, "R12 clear bit not stored", ctl_rdata, 16'h000D);
      bus_start();
      send_byte(8'h00, ack);
      send_byte(8'h22, ack);
      bus_stop();
      chk(status[2:0] == 3'b101, "R10 plain general call id", status[2:0], 3'b101);

      // R6: automatic hold when no byte is loaded
      wr_ctl(16'h0001);
      bus_start();
      send_byte({OWN, 1'b1}, ack);
      chk(ack == 1'b1, "R6 read address ack", ack, 1);
      sda_m = 1'b1;  wt(Q);
      scl_m = 1'b1;  wt(100);
      chk(scl_bus == 1'b0, "R6 SCL held without data", scl_bus, 0);
      load_tx(8'hE7);
      wait_high();  wt(H / 2);
      got[7] = sda_bus;  wt(H / 2);
      scl_m = 1'b0;  wt(Q);
      for (int i = 6; i >= 0; i--) begin
         logic b;
         read_bit(b);
         got[i] = b;
      end
      write_bit(1'b1);
      bus_stop();
      chk(got == 8'hE7, "R6 byte after release", got, 8'hE7);

      // R7: firmware hold, bit set while SCL high then while SCL low
      wr_ctl(16'h0041);
      wt(40);
      chk(scl_bus == 1'b1, "R7 no hold while SCL stays high", scl_bus, 1);
      scl_m = 1'b0;  wt(20);
      scl_m = 1'b1;  wt(60);
      chk(scl_bus == 1'b0, "R7 hold after falling edge", scl_bus, 0);
      wr_ctl(16'h0001);
      wt(10);
      chk(scl_bus == 1'b1, "R7 release on clear", scl_bus, 1);
      scl_m = 1'b0;  wt(10);
      wr_ctl(16'h0041);
      scl_m = 1'b1;  wt(60);
      chk(scl_bus == 1'b0, "R7 hold when set with SCL low", scl_bus, 0);
      wr_ctl(16'h0001);
      wt(10);
      chk(scl_bus == 1'b1, "R7 second release", scl_bus, 1);

      // R8: both request timings
      early_late(1'b1);
      early_late(1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule